// File: doc/BRIEF.md
# Full-Speed Frame Interval Timer

This block splits a stream of 12 MHz bit times into 1 ms frames for a full-speed host port. A down-counter starts at the programmed interval and drops by one on every bit-time enable while the timer runs. When it is at zero on an enabled tick, a frame boundary occurs. The counter reloads, the 16-bit frame number advances, and a one-cycle start-of-frame strobe is raised. A separate strobe marks every change of the frame number's top bit, whether it goes up or down.

Software writes one 32-bit timing register. The low half holds the interval in bit times minus one. The high half holds the largest data packet budget in bit times. After reset the register holds an interval of 11999 and a budget of 6*(11999-210)/7 = 10104. A write is stored at once but only takes effect at the next frame boundary. The remaining count is an output, so a scheduler can compare it with the budget before it starts a packet.

Top module: `sof_frame_timer`

## Requirements
- R1: After reset, frame_num is 0, remain is 11999, pkt_budget is 10104, and sof_pulse and fno_pulse are low.
- R2: The timing register holds the interval in bits [15:0] and the packet budget in bits [31:16]. Its reset content is 0x2778_2EDF.
- R3: In a cycle where run and bit_en are both high and remain is nonzero, remain drops by exactly one. If either input is low, remain keeps its value.
- R4: When remain is 0 on a cycle with run and bit_en high, remain reloads with the interval field and frame_num increments, wrapping at 16 bits. On the next cycle sof_pulse is high for that boundary, and frame_num already shows the new value. A frame therefore lasts interval+1 enabled ticks, which is 12000 by default.
- R5: A register write does not change remain or pkt_budget mid-frame. The written interval sets the reload value and the written budget appears on pkt_budget, both at the next frame boundary. A boundary in the same cycle as a write uses the earlier content.
- R6: fno_pulse is high in the same cycle as sof_pulse exactly when bit 15 of frame_num has just changed, from 0 to 1 or from 1 to 0.
- R7: While run is low, remain and frame_num hold their values and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Timer runs while high |
| bit_en | input | 1 | One-cycle enable per 12 MHz bit time |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_wdata | input | 32 | Write data: budget [31:16], interval [15:0] |
| sof_pulse | output | 1 | Start-of-frame strobe |
| fno_pulse | output | 1 | Frame number bit 15 toggle strobe |
| frame_num | output | 16 | Current frame number |
| pkt_budget | output | 16 | Active largest-packet budget |
| remain | output | 16 | Bit times left in the current frame |

## Verification
The assertions check on every cycle that the count steps down by one per enabled tick, that run low freezes the count and the frame number, that each start-of-frame shows a frame number one above the previous one, that the overflow strobe matches a flip of bit 15, and that the budget moves only at a boundary. Only the bench scenarios can show the absolute numbers: the 12000-tick default frame, the reset register content, how a write landing mid-frame is deferred, and that exactly two overflow strobes appear in 65536 one-tick frames.

// File: rtl/sof_pkg.sv
package sof_pkg;
  localparam int FIELD_W      = 16;
  localparam int DEF_INTERVAL = 11999;

  function automatic int budget_of(input int iv);
    return (6 * (iv - 210)) / 7;
  endfunction
endpackage

// File: rtl/frame_cfg_reg.sv
module frame_cfg_reg #(
  parameter int FIELD_W      = sof_pkg::FIELD_W,
  parameter int DEF_INTERVAL = sof_pkg::DEF_INTERVAL
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [2*FIELD_W-1:0] wr_data,
  input  logic                 boundary,
  output logic [FIELD_W-1:0]   reload_val,
  output logic [FIELD_W-1:0]   budget
);
  localparam int DEF_BUDGET = sof_pkg::budget_of(DEF_INTERVAL);
  localparam logic [2*FIELD_W-1:0] RST_WORD = {FIELD_W'(DEF_BUDGET), FIELD_W'(DEF_INTERVAL)};

  logic [2*FIELD_W-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst)        pend_q <= RST_WORD;
    else if (wr_en) pend_q <= wr_data;
  end

  assign reload_val = pend_q[FIELD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)           budget <= FIELD_W'(DEF_BUDGET);
    else if (boundary) budget <= pend_q[2*FIELD_W-1:FIELD_W];
  end

  p_budget_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(budget));
endmodule

// File: rtl/frame_down_counter.sv
module frame_down_counter #(
  parameter int FIELD_W      = sof_pkg::FIELD_W,
  parameter int DEF_INTERVAL = sof_pkg::DEF_INTERVAL
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               bit_en,
  input  logic [FIELD_W-1:0] reload_val,
  output logic [FIELD_W-1:0] remain,
  output logic               wrap
);
  logic tick;
  assign tick = run && bit_en;
  assign wrap = tick && (remain == '0);

  always_ff @(posedge clk) begin
    if (rst)       remain <= FIELD_W'(DEF_INTERVAL);
    else if (wrap) remain <= reload_val;
    else if (tick) remain <= remain - 1'b1;
  end

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run && bit_en && remain != '0) |=> remain == $past(remain) - 1'b1);
  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !(run && bit_en) |=> $stable(remain));
endmodule

// File: rtl/frame_number_ctr.sv
module frame_number_ctr #(
  parameter int FN_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wrap,
  output logic [FN_W-1:0] frame_num,
  output logic            sof,
  output logic            fno
);
  logic [FN_W-1:0] next_fn;
  assign next_fn = frame_num + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_num <= '0;
      sof       <= 1'b0;
      fno       <= 1'b0;
    end else begin
      sof <= wrap;
      fno <= wrap && (next_fn[FN_W-1] != frame_num[FN_W-1]);
      if (wrap) frame_num <= next_fn;
    end
  end

  p_sof_num_r4: assert property (@(posedge clk) disable iff (rst)
    sof |-> frame_num == $past(frame_num) + 1'b1);
  p_fno_with_sof_r6: assert property (@(posedge clk) disable iff (rst)
    fno |-> sof);
  p_fno_dir_r6: assert property (@(posedge clk) disable iff (rst)
    sof |-> (fno == (frame_num[FN_W-1] != $past(frame_num[FN_W-1]))));
endmodule

// File: rtl/sof_frame_timer.sv
module sof_frame_timer #(
  parameter int FN_W         = 16,
  parameter int FIELD_W      = sof_pkg::FIELD_W,
  parameter int DEF_INTERVAL = sof_pkg::DEF_INTERVAL
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 bit_en,
  input  logic                 cfg_we,
  input  logic [2*FIELD_W-1:0] cfg_wdata,
  output logic                 sof_pulse,
  output logic                 fno_pulse,
  output logic [FN_W-1:0]      frame_num,
  output logic [FIELD_W-1:0]   pkt_budget,
  output logic [FIELD_W-1:0]   remain
);
  logic               wrap;
  logic [FIELD_W-1:0] reload_val;

  frame_cfg_reg #(.FIELD_W(FIELD_W), .DEF_INTERVAL(DEF_INTERVAL)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .boundary(wrap), .reload_val(reload_val), .budget(pkt_budget));

  frame_down_counter #(.FIELD_W(FIELD_W), .DEF_INTERVAL(DEF_INTERVAL)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .bit_en(bit_en),
    .reload_val(reload_val), .remain(remain), .wrap(wrap));

  frame_number_ctr #(.FN_W(FN_W)) u_num (
    .clk(clk), .rst(rst), .wrap(wrap),
    .frame_num(frame_num), .sof(sof_pulse), .fno(fno_pulse));

  p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(frame_num) && $stable(remain) && !sof_pulse);
endmodule

// File: tb/tb_sof_frame_timer.sv
module tb_sof_frame_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        bit_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        sof_pulse, fno_pulse;
  logic [15:0] frame_num, pkt_budget, remain;

  always #2 clk = ~clk;

  sof_frame_timer dut (
    .clk(clk), .rst(rst), .run(run), .bit_en(bit_en),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sof_pulse(sof_pulse), .fno_pulse(fno_pulse), .frame_num(frame_num),
    .pkt_budget(pkt_budget), .remain(remain));

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // reference model
  int m_rem, m_fn, m_bud, m_pint, m_pbud;
  bit m_sof, m_fno;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_rem <= 11999; m_fn <= 0; m_bud <= 10104;
      m_pint <= 11999; m_pbud <= 10104; m_sof <= 0; m_fno <= 0;
    end else begin
      bit edge_now;
      edge_now = run && bit_en && (m_rem == 0);
      m_sof <= edge_now;
      m_fno <= edge_now && (((m_fn + 1) % 65536) / 32768 != m_fn / 32768);
      if (edge_now) begin
        m_rem <= m_pint;
        m_fn  <= (m_fn + 1) % 65536;
        m_bud <= m_pbud;
      end else if (run && bit_en) begin
        m_rem <= m_rem - 1;
      end
      if (cfg_we) begin
        m_pint <= int'(cfg_wdata[15:0]);
        m_pbud <= int'(cfg_wdata[31:16]);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 remain", int'(remain), m_rem);
      chk("R4 frame_num", int'(frame_num), m_fn);
      chk("R4 sof_pulse", int'(sof_pulse), int'(m_sof));
      chk("R6 fno_pulse", int'(fno_pulse), int'(m_fno));
      chk("R5 pkt_budget", int'(pkt_budget), m_bud);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int k, nf, fr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 frame_num", int'(frame_num), 0);
    chk("R1 remain", int'(remain), 11999);
    chk("R1 budget", int'(pkt_budget), 10104);
    chk("R1 strobes", int'(sof_pulse) + int'(fno_pulse), 0);

    // R4 default frame length 12000 ticks
    run = 1; bit_en = 1;
    k = 0;
    do begin @(negedge clk); k++; end while (!sof_pulse && k < 13000);
    chk("R4 first frame ticks", k, 12000);
    chk("R4 frame_num at sof", int'(frame_num), 1);
    chk("R4 remain after reload", int'(remain), 11999);

    // R7 freeze
    repeat (100) @(negedge clk);
    fr = int'(remain);
    run = 0;
    repeat (50) @(negedge clk);
    chk("R7 remain frozen", int'(remain), fr);
    chk("R7 frame_num frozen", int'(frame_num), 1);
    run = 1;

    // R3 sparse enables
    for (int i = 0; i < 3000; i++) begin
      bit_en = ($urandom % 3) == 0;
      run = ($urandom % 8) != 0;
      @(negedge clk);
    end
    run = 1; bit_en = 1;

    // R2/R5 mid-frame write: budget 16, interval 5
    cfg_we = 1; cfg_wdata = 32'h0010_0005;
    @(negedge clk);
    cfg_we = 0;
    chk("R5 budget unchanged mid-frame", int'(pkt_budget), 10104);
    do @(negedge clk); while (!sof_pulse);
    chk("R2 budget field", int'(pkt_budget), 16);
    chk("R2 interval field", int'(remain), 5);
    k = 0;
    do begin @(negedge clk); k++; end while (!sof_pulse && k < 50);
    chk("R4 short frame ticks", k, 6);

    // R6 one-tick frames, 65536 frames
    cfg_we = 1; cfg_wdata = 32'h0000_0000;
    @(negedge clk);
    cfg_we = 0;
    do @(negedge clk); while (!sof_pulse);
    @(negedge clk);
    nf = 0;
    for (int i = 0; i < 65536; i++) begin
      if (fno_pulse) nf++;
      @(negedge clk);
    end
    chk("R6 overflow strobes in 65536 frames", nf, 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule